// File: doc/BRIEF.md
# Sliding Window Sum of Squares

This block produces the energy term used in the denominator of two-dimensional normalised cross-correlation. A greyscale image arrives in raster order, one pixel per accepted cycle. For every placement of a square window that fits completely inside the frame, the block reports the sum of the squared pixel values under that window, together with the window's top-left column and row.

Each pixel is squared when it arrives. The squares of the previous lines are kept in a chain of line stores, one store per earlier line of the window. A column sum is formed from the newest square and the buffered squares above it. A running horizontal accumulator adds each new column sum and removes the one that leaves the window. This gives one result per pixel once the window is filled, with one register of latency. The cross-product numerator, the square root and the division are computed by neighbouring logic.

Top module: `sq_window_energy`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `out_valid` is low.
- R2: A result equals the exact sum of the squares of the WIN×WIN pixels whose top-left corner is at (`out_x`, `out_y`).
- R3: No intermediate or final sum wraps. A window of all-maximum pixels (65535 at 16 bits) gives exactly WIN²·65535².
- R4: `out_valid` is high for a pixel exactly when its column is at least WIN-1 and its row is at least WIN-1. A full frame therefore yields (IMG_W-WIN+1)·(IMG_H-WIN+1) results.
- R5: `out_x` and `out_y` carry the column and row of the window's top-left pixel. These are the current pixel's column and row, each minus WIN-1.
- R6: The result for a pixel accepted at a clock edge is presented in the cycle that follows that edge.
- R7: A cycle with `in_valid` low produces no result, leaves `out_sum`, `out_x` and `out_y` unchanged, and does not advance any position or sum.
- R8: A pixel with `in_sof` high is taken as column 0, row 0, whatever position came before. Nothing from an earlier, possibly incomplete, frame affects later results.
- R9: A pixel with `in_eol` high, or one at column IMG_W-1, ends its line. The next pixel is column 0 of the following row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A pixel is offered this cycle |
| in_sof | input | 1 | The pixel is the first of a frame |
| in_eol | input | 1 | The pixel is the last of its line |
| in_pix | input | PIX_W | Unsigned greyscale pixel |
| out_valid | output | 1 | A window result is presented |
| out_sum | output | 2·PIX_W+clog2(WIN²) | Sum of squares over the window |
| out_x | output | clog2(IMG_W) | Window top-left column |
| out_y | output | clog2(IMG_H) | Window top-left row |

## Verification
A corrupted line store entry shows up on the next line's results that cover that column. A stale history entry in the horizontal accumulator shows up at the port as soon as that entry is subtracted, which is within WIN results. Position errors appear at once in `out_x`/`out_y` and in the count of results per frame. Every result of every frame is therefore compared against sums computed directly from the pixels. The frames include stalls, a frame cut short mid-line, and windows of all-maximum pixels.

// File: rtl/swss_pkg.sv
package swss_pkg;

    localparam int DEF_PIX_W = 16;
    localparam int DEF_WIN   = 8;
    localparam int DEF_IMG_W = 1024;
    localparam int DEF_IMG_H = 768;

    // width of a column sum of win squares
    function automatic int col_bits(int pw, int win);
        return 2 * pw + $clog2(win);
    endfunction

    // width of a full win x win sum of squares
    function automatic int win_bits(int pw, int win);
        return 2 * pw + $clog2(win * win);
    endfunction

endpackage

// File: rtl/sq_line_store.sv
module sq_line_store
    import swss_pkg::*;
#(
    parameter int PIX_W = DEF_PIX_W,
    parameter int WIN   = DEF_WIN,
    parameter int IMG_W = DEF_IMG_W,
    localparam int XW    = $clog2(IMG_W),
    localparam int SQ_W  = 2 * PIX_W,
    localparam int COL_W = col_bits(PIX_W, WIN)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [XW-1:0]    col,
    input  logic [PIX_W-1:0] pix,
    output logic [COL_W-1:0] col_sum
);

    logic [SQ_W-1:0] pix_ext;
    logic [SQ_W-1:0] sq;
    logic [SQ_W-1:0] rd [WIN-1];

    assign pix_ext = {{PIX_W{1'b0}}, pix};
    assign sq      = pix_ext * pix_ext;

    // store k holds the squares of line (current - 1 - k)
    for (genvar k = 0; k < WIN - 1; k++) begin : g_line
        logic [SQ_W-1:0] mem [IMG_W];
        logic [SQ_W-1:0] wdata;

        assign rd[k] = mem[col];

        if (k == 0) begin : g_head
            assign wdata = sq;
        end else begin : g_tail
            assign wdata = rd[k-1];
        end

        always_ff @(posedge clk) begin
            if (wr_en) begin
                mem[col] <= wdata;
            end
        end
    end

    always_comb begin
        col_sum = COL_W'(sq);
        for (int k = 0; k < WIN - 1; k++) begin
            col_sum = col_sum + COL_W'(rd[k]);
        end
    end

endmodule

// File: rtl/win_row_accum.sv
module win_row_accum
    import swss_pkg::*;
#(
    parameter int PIX_W = DEF_PIX_W,
    parameter int WIN   = DEF_WIN,
    parameter int IMG_W = DEF_IMG_W,
    localparam int XW    = $clog2(IMG_W),
    localparam int COL_W = col_bits(PIX_W, WIN),
    localparam int SUM_W = win_bits(PIX_W, WIN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             frame_start,
    input  logic [XW-1:0]    col,
    input  logic [COL_W-1:0] col_sum,
    output logic [SUM_W-1:0] win_sum
);

    localparam logic [XW-1:0] WIN_X = XW'(WIN);

    logic [COL_W-1:0] hist [WIN];
    logic [SUM_W-1:0] acc;
    logic [SUM_W-1:0] base;
    logic [COL_W-1:0] drop;

    always_comb begin
        base    = (col == '0) ? '0 : acc;
        drop    = (col >= WIN_X) ? hist[WIN-1] : '0;
        win_sum = base + SUM_W'(col_sum) - SUM_W'(drop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            for (int i = 0; i < WIN; i++) hist[i] <= '0;
        end else if (en) begin
            acc     <= win_sum;
            hist[0] <= col_sum;
            for (int i = 1; i < WIN; i++) begin
                hist[i] <= frame_start ? '0 : hist[i-1];
            end
        end
    end

endmodule

// File: rtl/sq_window_energy.sv
module sq_window_energy
    import swss_pkg::*;
#(
    parameter int PIX_W = DEF_PIX_W,
    parameter int WIN   = DEF_WIN,
    parameter int IMG_W = DEF_IMG_W,
    parameter int IMG_H = DEF_IMG_H,
    localparam int XW    = $clog2(IMG_W),
    localparam int YW    = $clog2(IMG_H),
    localparam int SUM_W = win_bits(PIX_W, WIN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eol,
    input  logic [PIX_W-1:0] in_pix,
    output logic             out_valid,
    output logic [SUM_W-1:0] out_sum,
    output logic [XW-1:0]    out_x,
    output logic [YW-1:0]    out_y
);

    localparam int COL_W = col_bits(PIX_W, WIN);
    localparam logic [XW-1:0] LAST_X = XW'(IMG_W - 1);
    localparam logic [YW-1:0] LAST_Y = YW'(IMG_H - 1);
    localparam logic [XW-1:0] OFF_X  = XW'(WIN - 1);
    localparam logic [YW-1:0] OFF_Y  = YW'(WIN - 1);

    typedef struct packed {
        logic [XW-1:0] x;
        logic [YW-1:0] y;
    } pos_t;

    pos_t             nxt_q;
    pos_t             cur;
    logic             line_end;
    logic             hit;
    logic [COL_W-1:0] col_sum;
    logic [SUM_W-1:0] win_sum;

    always_comb begin
        cur      = in_sof ? '0 : nxt_q;
        line_end = in_eol || (cur.x == LAST_X);
        hit      = (cur.x >= OFF_X) && (cur.y >= OFF_Y);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nxt_q <= '0;
        end else if (in_valid) begin
            if (line_end) begin
                nxt_q.x <= '0;
                nxt_q.y <= (cur.y == LAST_Y) ? '0 : cur.y + 1'b1;
            end else begin
                nxt_q.x <= cur.x + 1'b1;
                nxt_q.y <= cur.y;
            end
        end
    end

    sq_line_store #(
        .PIX_W (PIX_W),
        .WIN   (WIN),
        .IMG_W (IMG_W)
    ) lines_i (
        .clk     (clk),
        .wr_en   (in_valid),
        .col     (cur.x),
        .pix     (in_pix),
        .col_sum (col_sum)
    );

    win_row_accum #(
        .PIX_W (PIX_W),
        .WIN   (WIN),
        .IMG_W (IMG_W)
    ) rows_i (
        .clk         (clk),
        .rst         (rst),
        .en          (in_valid),
        .frame_start (in_sof),
        .col         (cur.x),
        .col_sum     (col_sum),
        .win_sum     (win_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sum   <= '0;
            out_x     <= '0;
            out_y     <= '0;
        end else begin
            out_valid <= in_valid && hit;
            if (in_valid && hit) begin
                out_sum <= win_sum;
                out_x   <= cur.x - OFF_X;
                out_y   <= cur.y - OFF_Y;
            end
        end
    end

endmodule

// File: rtl/swss_check.sv
module swss_check
    import swss_pkg::*;
#(
    parameter int PIX_W = DEF_PIX_W,
    parameter int WIN   = DEF_WIN,
    parameter int IMG_W = DEF_IMG_W,
    parameter int IMG_H = DEF_IMG_H,
    localparam int XW    = $clog2(IMG_W),
    localparam int YW    = $clog2(IMG_H),
    localparam int SUM_W = win_bits(PIX_W, WIN)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_sof,
    input logic             out_valid,
    input logic [SUM_W-1:0] out_sum,
    input logic [XW-1:0]    out_x,
    input logic [YW-1:0]    out_y
);

    localparam logic [SUM_W-1:0] MAXP    = (SUM_W'(1) << PIX_W) - SUM_W'(1);
    localparam logic [SUM_W-1:0] MAX_SUM = SUM_W'(WIN * WIN) * MAXP * MAXP;
    localparam logic [XW-1:0]    LIM_X   = XW'(IMG_W - WIN);
    localparam logic [YW-1:0]    LIM_Y   = YW'(IMG_H - WIN);

    assert_reset_R1: assert property (@(posedge clk) rst |=> !out_valid);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_sum <= MAX_SUM);

    assert_region_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_x <= LIM_X) && (out_y <= LIM_Y));

    assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_sum) && $stable(out_x) && $stable(out_y));

    assert_sof_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sof) |=> !out_valid);

endmodule

bind sq_window_energy swss_check #(
    .PIX_W (PIX_W),
    .WIN   (WIN),
    .IMG_W (IMG_W),
    .IMG_H (IMG_H)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .out_valid (out_valid),
    .out_sum   (out_sum),
    .out_x     (out_x),
    .out_y     (out_y)
);

// File: tb/sq_window_energy_tb_top.sv
`timescale 1ns/1ps
module sq_window_energy_tb_top;

    localparam int PW = 16;
    localparam int WN = 3;
    localparam int W  = 10;
    localparam int H  = 7;
    localparam int XW = $clog2(W);
    localparam int YW = $clog2(H);
    localparam int SW = 2 * PW + $clog2(WN * WN);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_sof = 1'b0;
    logic          in_eol = 1'b0;
    logic [PW-1:0] in_pix = '0;
    logic          out_valid;
    logic [SW-1:0] out_sum;
    logic [XW-1:0] out_x;
    logic [YW-1:0] out_y;

    always #2 clk = ~clk;

    sq_window_energy #(.PIX_W(PW), .WIN(WN), .IMG_W(W), .IMG_H(H)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_eol(in_eol), .in_pix(in_pix), .out_valid(out_valid),
        .out_sum(out_sum), .out_x(out_x), .out_y(out_y)
    );

    int total = 0;
    int bad = 0;
    int nres = 0;
    bit done = 0;
    logic [PW-1:0] img [H][W];

    task automatic chk(bit ok, string req, longint unsigned act, longint unsigned exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic longint unsigned energy(int x0, int y0);
        longint unsigned s = 0;
        for (int dy = 0; dy < WN; dy++)
            for (int dx = 0; dx < WN; dx++) begin
                longint unsigned p = img[y0+dy][x0+dx];
                s += p * p;
            end
        return s;
    endfunction

    // drive one pixel at a falling edge, check its result at the next one (R6)
    task automatic send(int x, int y, bit sof, bit eol);
        bit exp_v;
        in_valid = 1'b1; in_sof = sof; in_eol = eol; in_pix = img[y][x];
        @(negedge clk);
        exp_v = (x >= WN - 1) && (y >= WN - 1);
        chk(out_valid == exp_v, "R4/R6 valid", out_valid, exp_v);
        if (exp_v && out_valid) begin
            nres++;
            chk(out_sum == SW'(energy(x - WN + 1, y - WN + 1)), "R2 sum",
                out_sum, energy(x - WN + 1, y - WN + 1));
            chk(out_x == XW'(x - WN + 1), "R5 x", out_x, x - WN + 1);
            chk(out_y == YW'(y - WN + 1), "R5 y", out_y, y - WN + 1);
        end
    endtask

    task automatic idle(int n);
        logic [SW-1:0] held;
        held = out_sum;
        in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0; in_pix = '1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(!out_valid, "R7 no result while stalled", out_valid, 0);
            chk(out_sum == held, "R7 sum held", out_sum, held);
        end
    endtask

    // sends npix pixels of img in raster order, eol on last column (R9)
    task automatic frame(int npix, bit gaps);
        int k = 0;
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) begin
                if (k < npix) begin
                    send(x, y, (x == 0 && y == 0), (x == W - 1));
                    if (gaps && ($urandom % 4 == 0)) idle(1 + $urandom % 3);
                end
                k++;
            end
    endtask

    initial begin
        @(negedge clk);
        chk(!out_valid, "R1 during reset", out_valid, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid, "R1 after reset", out_valid, 0);

        // ramp frame
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) img[y][x] = PW'(y * W + x + 1);
        nres = 0;
        frame(W * H, 0);
        chk(nres == (W - WN + 1) * (H - WN + 1), "R4 count ramp", nres, (W - WN + 1) * (H - WN + 1));
        idle(2);

        // all-maximum frame (R3)
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) img[y][x] = '1;
        nres = 0;
        frame(W * H, 0);
        chk(out_sum == SW'(longint'(WN * WN) * 65535 * 65535), "R3 max window",
            out_sum, longint'(WN * WN) * 65535 * 65535);
        chk(nres == (W - WN + 1) * (H - WN + 1), "R4 count max", nres, (W - WN + 1) * (H - WN + 1));

        // random frame with stalls (R7)
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) img[y][x] = PW'($urandom);
        nres = 0;
        frame(W * H, 1);
        chk(nres == (W - WN + 1) * (H - WN + 1), "R4 count stalled", nres, (W - WN + 1) * (H - WN + 1));

        // frame cut short mid-line, then a fresh frame (R8)
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) img[y][x] = PW'($urandom);
        frame(4 * W + 5, 0);
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) img[y][x] = PW'((x * 7 + y * 13) * 97);
        nres = 0;
        frame(W * H, 1);
        chk(nres == (W - WN + 1) * (H - WN + 1), "R8 count after restart", nres, (W - WN + 1) * (H - WN + 1));

        idle(2);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule